// File: doc/BRIEF.md
# Temperature-Indexed Lookup DAC Controller

This block turns an 8-bit thermometer reading into an 8-bit DAC code through a 64-entry byte table held in its own register space. A host reaches the table and a handful of control registers over a simple byte bus. The bus has an address, write data, write and read strobes, combinational read data and a write acknowledge. By default the upper six bits of the reading pick a table row, and that row's byte becomes the DAC code. Two bypass multiplexers let the host override this path. One forces the row index from a register. The other forces the DAC code itself from a register.

Every write is gated by a write-enable latch. The host arms the latch with one exact code and disarms it with another, both written to the latch register. While the latch is clear, writes elsewhere are dropped without acknowledge. The block also holds a 2-bit full-scale range code for the analog output stage, and it never lets that code become the reserved value.

Address map: row register 0x81, DAC code register 0x83, configuration 0x85, latch 0x86, reading 0x87 (read-only), table 0x90 to 0xCF.

Top module: `tlut_dac_ctrl`

## Requirements
- R1: After reset, dac_code is 0x00, fs_range is 2'b11, the latch reads 0x00 at 0x86, and 0x85 reads 0x03.
- R2: Writing exactly 0x80 to 0x86 sets the latch, and writing exactly 0x00 clears it. Either write is accepted whatever the latch state. Any other value written to 0x86 changes nothing and is not acknowledged. Reading 0x86 returns the latch in bit 7, with all other bits 0.
- R3: While the latch is 0, a write to any address other than 0x86 changes no register or table byte and is not acknowledged.
- R4: An accepted write raises bus_ack for exactly the one cycle after the clock edge that captured the write strobe.
- R5: With row bypass off, the row index is adc_code[7:2], and dac_code equals the table byte at 0x90 plus that index.
- R6: Bit 4 of 0x85 is the row bypass. When it is 1, the row index is bits 5:0 of 0x81. When it is 0, 0x81 has no effect on dac_code. 0x81 reads back as {2'b00, index}.
- R7: Bit 5 of 0x85 is the DAC bypass. When it is 1, dac_code equals the byte at 0x83, and changes to the table or to adc_code have no effect. It resets to 0.
- R8: Bits 1:0 of 0x85 drive fs_range (01 is the low range, 10 the middle range, 11 the high range). Writing 00 to these bits keeps the previous code, while the other bits of that write still take effect. 0x85 reads as {2'b00, dacbyp, rowbyp, 2'b00, fs}.
- R9: Reading 0x87 returns adc_code. Writes to 0x87 are ignored and not acknowledged.
- R10: Reading an unmapped address returns 0x00. A write to an unmapped address is not acknowledged.
- R11: dac_code is registered. It moves on the first clock edge after a change of adc_code, and on the second clock edge after a write to a register or table byte that feeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, otherwise 0 |
| bus_ack | output | 1 | Write accepted, one cycle after the strobe |
| adc_code | input | 8 | Thermometer reading (0x00 for the coldest point, 0xFF for the hottest) |
| dac_code | output | 8 | Registered DAC input code |
| fs_range | output | 2 | Full-scale range code |

## Verification
A latch stuck high shows up at once: a write to a table byte is acknowledged and read back although it should have been dropped. A latch stuck low shows up as missing acknowledges one cycle after the strobe. A wrong bypass bit or a wrong row index shows on dac_code within two edges of the write, or one edge after the reading changes. The bench drives known table contents and readings and checks that code against values it computes itself. A full-scale code that slips to the reserved value is visible immediately on fs_range and at 0x85.

// File: rtl/tlut_pkg.sv
package tlut_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int ROW_W    = 6;
    localparam int TBL_ROWS = 1 << ROW_W;

    localparam logic [ADDR_W-1:0] A_ROWDIR = 8'h81;
    localparam logic [ADDR_W-1:0] A_DACDIR = 8'h83;
    localparam logic [ADDR_W-1:0] A_CFG    = 8'h85;
    localparam logic [ADDR_W-1:0] A_WEL    = 8'h86;
    localparam logic [ADDR_W-1:0] A_ADC    = 8'h87;
    localparam logic [ADDR_W-1:0] TBL_BASE = 8'h90;
    localparam logic [ADDR_W-1:0] TBL_LAST = TBL_BASE + ADDR_W'(TBL_ROWS - 1);

    localparam logic [DATA_W-1:0] WEL_ARM    = 8'h80;
    localparam logic [DATA_W-1:0] WEL_DISARM = 8'h00;
    localparam logic [1:0]        FS_RESET   = 2'b11;
    localparam logic [1:0]        FS_RSVD    = 2'b00;

    typedef enum logic [2:0] {
        RG_NONE, RG_ROWDIR, RG_DACDIR, RG_CFG, RG_WEL, RG_ADC, RG_TBL
    } region_e;

    typedef struct packed {
        logic       dac_byp;
        logic       row_byp;
        logic [1:0] fs;
    } cfg_t;

    function automatic region_e decode(input logic [ADDR_W-1:0] a);
        if (a >= TBL_BASE && a <= TBL_LAST) return RG_TBL;
        case (a)
            A_ROWDIR: return RG_ROWDIR;
            A_DACDIR: return RG_DACDIR;
            A_CFG:    return RG_CFG;
            A_WEL:    return RG_WEL;
            A_ADC:    return RG_ADC;
            default:  return RG_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(input cfg_t c);
        return {2'b00, c.dac_byp, c.row_byp, 2'b00, c.fs};
    endfunction
endpackage

// File: rtl/tlut_regs.sv
module tlut_regs
    import tlut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  region_e           region,
    input  logic [DATA_W-1:0] wdata,
    output logic              accept,
    output logic [ROW_W-1:0]  row_dir,
    output logic [DATA_W-1:0] dac_dir,
    output cfg_t              cfg,
    output logic              wel
);
    always_comb begin
        case (region)
            RG_WEL:    accept = (wdata == WEL_ARM) || (wdata == WEL_DISARM);
            RG_ROWDIR,
            RG_DACDIR,
            RG_CFG,
            RG_TBL:    accept = wel;
            default:   accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_dir <= '0;
            dac_dir <= '0;
            cfg     <= '{dac_byp: 1'b0, row_byp: 1'b0, fs: FS_RESET};
            wel     <= 1'b0;
        end else if (wr && accept) begin
            case (region)
                RG_ROWDIR: row_dir <= wdata[ROW_W-1:0];
                RG_DACDIR: dac_dir <= wdata;
                RG_CFG: begin
                    cfg.dac_byp <= wdata[5];
                    cfg.row_byp <= wdata[4];
                    if (wdata[1:0] != FS_RSVD) cfg.fs <= wdata[1:0];
                end
                RG_WEL:    wel <= (wdata == WEL_ARM);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tlut_table.sv
module tlut_table
    import tlut_pkg::*;
#(
    parameter int ROWS = TBL_ROWS,
    localparam int IW  = $clog2(ROWS)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IW-1:0]     host_row,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IW-1:0]     sel_row,
    output logic [DATA_W-1:0] sel_byte,
    output logic [DATA_W-1:0] host_byte
);
    logic [DATA_W-1:0] mem [ROWS];

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)                              mem[i] <= '0;
            else if (we && host_row == IW'(i))    mem[i] <= wdata;
        end
    end

    assign sel_byte  = mem[sel_row];
    assign host_byte = mem[host_row];
endmodule

// File: rtl/tlut_sel.sv
module tlut_sel
    import tlut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic [ROW_W-1:0]  adc_row,
    input  logic [ROW_W-1:0]  row_dir,
    input  logic [DATA_W-1:0] dac_dir,
    input  logic [DATA_W-1:0] tbl_byte,
    output logic [ROW_W-1:0]  sel_row,
    output logic [DATA_W-1:0] dac_code
);
    logic [DATA_W-1:0] dac_next;

    assign sel_row  = cfg.row_byp ? row_dir : adc_row;
    assign dac_next = cfg.dac_byp ? dac_dir : tbl_byte;

    always_ff @(posedge clk) begin
        if (rst) dac_code <= '0;
        else     dac_code <= dac_next;
    end
endmodule

// File: rtl/tlut_dac_ctrl.sv
module tlut_dac_ctrl
    import tlut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    input  logic [DATA_W-1:0] adc_code,
    output logic [DATA_W-1:0] dac_code,
    output logic [1:0]        fs_range
);
    region_e           region;
    logic              accept;
    logic              wel_q;
    cfg_t              cfg_q;
    logic [ROW_W-1:0]  row_dir_q;
    logic [DATA_W-1:0] dac_dir_q;
    logic [ROW_W-1:0]  host_row;
    logic [ROW_W-1:0]  sel_row;
    logic [DATA_W-1:0] sel_byte;
    logic [DATA_W-1:0] host_byte;
    logic              tbl_we;

    assign region   = decode(bus_addr);
    assign host_row = ROW_W'(bus_addr - TBL_BASE);
    assign tbl_we   = bus_wr && accept && (region == RG_TBL);
    assign fs_range = cfg_q.fs;

    tlut_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .region(region), .wdata(bus_wdata),
        .accept(accept), .row_dir(row_dir_q), .dac_dir(dac_dir_q),
        .cfg(cfg_q), .wel(wel_q)
    );

    tlut_table #(.ROWS(TBL_ROWS)) u_tbl (
        .clk(clk), .rst(rst), .we(tbl_we), .host_row(host_row),
        .wdata(bus_wdata), .sel_row(sel_row), .sel_byte(sel_byte),
        .host_byte(host_byte)
    );

    tlut_sel u_sel (
        .clk(clk), .rst(rst), .cfg(cfg_q), .adc_row(adc_code[DATA_W-1 -: ROW_W]),
        .row_dir(row_dir_q), .dac_dir(dac_dir_q), .tbl_byte(sel_byte),
        .sel_row(sel_row), .dac_code(dac_code)
    );

    always_ff @(posedge clk) begin
        if (rst) bus_ack <= 1'b0;
        else     bus_ack <= bus_wr && accept;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (region)
                RG_ROWDIR: bus_rdata = {{(DATA_W-ROW_W){1'b0}}, row_dir_q};
                RG_DACDIR: bus_rdata = dac_dir_q;
                RG_CFG:    bus_rdata = cfg_pack(cfg_q);
                RG_WEL:    bus_rdata = {wel_q, {(DATA_W-1){1'b0}}};
                RG_ADC:    bus_rdata = adc_code;
                RG_TBL:    bus_rdata = host_byte;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tlut_chk.sv
module tlut_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       bus_ack,
    input logic [1:0] fs_range,
    input logic [7:0] dac_code,
    input logic       wel_q,
    input logic       dac_byp,
    input logic [7:0] dac_dir
);
    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !wel_q && bus_addr != 8'h86) |=> !bus_ack);

    // R2
    wel_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h86 && bus_wdata == 8'h80) |=> (wel_q && bus_ack));

    // R2
    wel_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h86 && bus_wdata == 8'h00) |=> !wel_q);

    // R8
    fs_not_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        fs_range != 2'b00);

    // R7
    dac_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        dac_byp |=> (dac_code == $past(dac_dir)));

    // R9
    adc_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h87) |=> !bus_ack);

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr < 8'h81) |-> bus_rdata == 8'h00);

    // R4
    ack_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> $past(bus_wr));
endmodule

bind tlut_dac_ctrl tlut_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .fs_range(fs_range), .dac_code(dac_code), .wel_q(wel_q),
    .dac_byp(cfg_q.dac_byp), .dac_dir(dac_dir_q)
);

// File: tb/sim_tlut_dac_ctrl.sv
module sim_tlut_dac_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       bus_ack;
    logic [7:0] adc_code = '0;
    logic [7:0] dac_code;
    logic [1:0] fs_range;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    tlut_dac_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .adc_code(adc_code), .dac_code(dac_code), .fs_range(fs_range)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit exp_ack,
                      input string tag);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(tag, int'(bus_ack), int'(exp_ack));
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(tag, int'(bus_rdata), int'(exp));
        bus_rd = 1'b0;
    endtask

    task automatic dac_after_write(input logic [7:0] exp, input string tag);
        @(posedge clk);
        #2 check(tag, int'(dac_code), int'(exp));
    endtask

    task automatic adc_step(input logic [7:0] v, input logic [7:0] old_v,
                            input logic [7:0] new_v, input string tag);
        @(negedge clk);
        adc_code = v;
        #1 check({tag, " hold"}, int'(dac_code), int'(old_v));
        @(posedge clk);
        #2 check({tag, " new"}, int'(dac_code), int'(new_v));
    endtask

    task automatic t_reset;
        check("R1 dac", int'(dac_code), 0);
        check("R1 fs", int'(fs_range), 3);
        rd(8'h86, 8'h00, "R1 latch");
        rd(8'h85, 8'h03, "R1 cfg");
    endtask

    task automatic t_lock;
        wr(8'h95, 8'hEE, 1'b0, "R3 locked table ack");
        rd(8'h95, 8'h00, "R3 locked table data");
        wr(8'h83, 8'h44, 1'b0, "R3 locked reg ack");
        rd(8'h83, 8'h00, "R3 locked reg data");
        wr(8'h86, 8'h55, 1'b0, "R2 odd code ack");
        rd(8'h86, 8'h00, "R2 odd code latch");
        wr(8'h86, 8'h80, 1'b1, "R2 R4 arm ack");
        @(negedge clk);
        check("R4 ack one cycle", int'(bus_ack), 0);
        rd(8'h86, 8'h80, "R2 armed latch");
        wr(8'h86, 8'h81, 1'b0, "R2 near code");
        rd(8'h86, 8'h80, "R2 latch held");
    endtask

    task automatic t_table_path;
        wr(8'h90, 8'h11, 1'b1, "R4 row0");
        wr(8'h95, 8'hA5, 1'b1, "R4 row5");
        wr(8'hA4, 8'h77, 1'b1, "R4 row20");
        wr(8'hCF, 8'h3C, 1'b1, "R4 row63");
        rd(8'hCF, 8'h3C, "R5 row63 read");
        adc_step(8'h17, 8'h11, 8'hA5, "R5 R11 row5");
        adc_step(8'hFF, 8'hA5, 8'h3C, "R5 R11 row63");
        adc_step(8'h02, 8'h3C, 8'h11, "R5 R11 row0");
    endtask

    task automatic t_row_bypass;
        wr(8'h81, 8'hD4, 1'b1, "R6 row reg ack");
        dac_after_write(8'h11, "R6 ignored while off");
        rd(8'h81, 8'h14, "R6 readback");
        wr(8'h85, 8'h13, 1'b1, "R6 bypass on");
        dac_after_write(8'h77, "R6 R11 forced row20");
        adc_step(8'hFF, 8'h77, 8'h77, "R6 adc ignored");
        wr(8'hA4, 8'h78, 1'b1, "R11 table edit");
        dac_after_write(8'h78, "R11 table edit seen");
    endtask

    task automatic t_dac_bypass;
        wr(8'h83, 8'h9B, 1'b1, "R7 dac reg ack");
        wr(8'h85, 8'h33, 1'b1, "R7 bypass on");
        dac_after_write(8'h9B, "R7 forced code");
        wr(8'hA4, 8'h01, 1'b1, "R7 table edit");
        dac_after_write(8'h9B, "R7 table ignored");
        adc_step(8'h00, 8'h9B, 8'h9B, "R7 adc ignored");
        rd(8'h85, 8'h33, "R7 cfg read");
    endtask

    task automatic t_range;
        wr(8'h85, 8'h01, 1'b1, "R8 low range");
        check("R8 fs 01", int'(fs_range), 1);
        dac_after_write(8'h11, "R8 bypasses cleared");
        wr(8'h85, 8'h20, 1'b1, "R8 reserved write ack");
        check("R8 fs held", int'(fs_range), 1);
        rd(8'h85, 8'h21, "R8 other bits applied");
        wr(8'h85, 8'h02, 1'b1, "R8 mid range");
        check("R8 fs 10", int'(fs_range), 2);
    endtask

    task automatic t_ro_unmapped;
        @(negedge clk) adc_code = 8'hC3;
        rd(8'h87, 8'hC3, "R9 adc read");
        wr(8'h87, 8'h00, 1'b0, "R9 write ack");
        rd(8'h87, 8'hC3, "R9 unchanged");
        rd(8'h20, 8'h00, "R10 read low");
        rd(8'hD0, 8'h00, "R10 read past table");
        wr(8'hD0, 8'h5A, 1'b0, "R10 write ack");
        wr(8'h84, 8'h5A, 1'b0, "R10 gap write ack");
    endtask

    task automatic t_disarm;
        wr(8'h86, 8'h00, 1'b1, "R2 disarm ack");
        rd(8'h86, 8'h00, "R2 disarmed");
        wr(8'h83, 8'h12, 1'b0, "R3 relocked ack");
        rd(8'h83, 8'h9B, "R3 relocked data");
        wr(8'h86, 8'h00, 1'b1, "R2 disarm while clear");
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset;
        t_lock;
        t_table_path;
        t_row_bypass;
        t_dac_bypass;
        t_range;
        t_ro_unmapped;
        t_disarm;
        repeat (2) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule